// File: doc/BRIEF.md
# Tag-Matching Reservation Station Bank

This block holds the operations waiting for one class of execution unit, for example a group of floating-point adders. Each slot stores an operation code and two source operands. Each operand is present either as a value or as the tag of the station that will produce it. The issue logic writes a new operation into a free slot. From then on the bank listens to a single result broadcast bus, and any operand waiting on the broadcast tag picks up the data in that cycle. Values are never read from a register file.

Each cycle, the oldest-positioned slot whose operands are both present and which has not yet been sent is presented to the execution unit. The unit takes the presented operation in that same cycle. A slot keeps its place until its own result appears on the broadcast bus, and then it becomes free. Every slot has a fixed, nonzero, machine-wide tag equal to `BASE_TAG` plus its index. A tag of zero means that an operand is already present.

Top module: `rs_bank`

## Requirements
- R1: After a synchronous reset every slot is free: `iss_ready` is 1, `iss_tag` equals `BASE_TAG`, and `disp_valid` is 0.
- R2: An issue (`iss_valid` with `iss_ready`) writes the lowest-indexed free slot. `iss_tag` always shows the tag of the slot the next issue will take, which is `BASE_TAG` plus the slot index. An operand issued with tag 0 takes its issued value.
- R3: When every slot is busy, `iss_ready` is 0 and an issue attempt changes no slot.
- R4: A slot is not dispatched while either of its operand tags is nonzero.
- R5: When `bc_valid` is high and `bc_tag` equals a waiting operand's nonzero tag, that operand takes `bc_data` and becomes present. The slot can be dispatched from the next cycle.
- R6: A broadcast carrying a busy slot's own tag frees that slot from the next cycle onward.
- R7: One broadcast fills every operand waiting on its tag in the same cycle. Each slot released this way is then dispatched on consecutive cycles.
- R8: `disp_valid` shows the lowest-indexed slot that has both operands and has not yet been dispatched. Each slot is dispatched exactly once per occupancy, in the cycle `disp_valid` shows it.
- R9: If an issued operand's tag equals the tag being broadcast in the same cycle, the new slot stores the broadcast data as a present value.
- R10: A broadcast whose tag matches no waiting operand and no busy slot leaves the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code to store |
| iss_a_val | input | DATA_W | First operand value (used when its tag is 0) |
| iss_a_tag | input | TAG_W | First operand producer tag, 0 if present |
| iss_b_val | input | DATA_W | Second operand value (used when its tag is 0) |
| iss_b_tag | input | TAG_W | Second operand producer tag, 0 if present |
| iss_ready | output | 1 | A free slot exists |
| iss_tag | output | TAG_W | Tag of the slot the next issue takes |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the producing station |
| bc_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A slot is sent to the unit this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched slot |
| disp_op | output | OP_W | Operation code of the dispatched slot |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |

## Verification
The assertions assume three things about the inputs. The issue logic never names a slot of this bank as the producer of its own operands. A broadcast carrying a slot's own tag arrives only after that slot has been dispatched. Issue requests are made only while `iss_ready` is high, apart from attempts that test rejection. The directed stimulus follows these rules. External producers use tags 4 to 9, and those tags never collide with the bank's tags 1 to 3. Each slot is freed only after the bench has seen it dispatched. The one issue made against a full bank carries operands that are both ready, so an illegal write would show up at the dispatch port.

// File: rtl/rs_bank_pkg.sv
package rs_bank_pkg;

    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;
    localparam int OP_W   = 4;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OP_W-1:0]   op_t;

    // One slot's stored state; a zero tag marks its value as valid
    typedef struct packed {
        logic  busy;
        logic  exec;
        op_t   op;
        data_t va;
        tag_t  qa;
        data_t vb;
        tag_t  qb;
    } slot_t;

endpackage

// File: rtl/rs_pick.sv
// Lowest-index priority picker: one-hot grant, encoded index, any-request flag
module rs_pick #(
    parameter int N   = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt      = '0;
                gnt[i]   = 1'b1;
                idx      = IW'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_bank_pkg::*;
#(
    parameter int MY_TAG = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc,
    input  op_t   iss_op,
    input  data_t iss_a_val,
    input  tag_t  iss_a_tag,
    input  data_t iss_b_val,
    input  tag_t  iss_b_tag,
    input  logic  bc_valid,
    input  tag_t  bc_tag,
    input  data_t bc_data,
    input  logic  dispatch_go,
    output logic  busy,
    output logic  ready,
    output op_t   op,
    output data_t va,
    output data_t vb
);
    localparam tag_t OWN_TAG = tag_t'(MY_TAG);

    slot_t st_d, st_q;
    logic  cap_a, cap_b, own_done;
    logic  byp_a, byp_b;

    always_comb begin
        st_d     = st_q;
        cap_a    = bc_valid && (st_q.qa != '0) && (st_q.qa == bc_tag);
        cap_b    = bc_valid && (st_q.qb != '0) && (st_q.qb == bc_tag);
        own_done = bc_valid && (bc_tag == OWN_TAG);
        byp_a    = bc_valid && (iss_a_tag != '0) && (iss_a_tag == bc_tag);
        byp_b    = bc_valid && (iss_b_tag != '0) && (iss_b_tag == bc_tag);

        if (st_q.busy) begin
            if (cap_a) begin
                st_d.va = bc_data;
                st_d.qa = '0;
            end
            if (cap_b) begin
                st_d.vb = bc_data;
                st_d.qb = '0;
            end
            if (dispatch_go) begin
                st_d.exec = 1'b1;
            end
            if (own_done) begin
                st_d.busy = 1'b0;
                st_d.exec = 1'b0;
            end
        end else if (alloc) begin
            st_d.busy = 1'b1;
            st_d.exec = 1'b0;
            st_d.op   = iss_op;
            if (byp_a) begin
                st_d.va = bc_data;
                st_d.qa = '0;
            end else begin
                st_d.va = (iss_a_tag == '0) ? iss_a_val : '0;
                st_d.qa = iss_a_tag;
            end
            if (byp_b) begin
                st_d.vb = bc_data;
                st_d.qb = '0;
            end else begin
                st_d.vb = (iss_b_tag == '0) ? iss_b_val : '0;
                st_d.qb = iss_b_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign ready = st_q.busy && !st_q.exec && (st_q.qa == '0) && (st_q.qb == '0);
    assign op    = st_q.op;
    assign va    = st_q.va;
    assign vb    = st_q.vb;

    AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !st_q.busy); // R3

    AST_DISP_OPERANDS_PRESENT: assert property (@(posedge clk) disable iff (rst)
        dispatch_go |-> (st_q.qa == '0 && st_q.qb == '0)); // R4

    AST_DISP_ONCE: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.exec) |-> !dispatch_go); // R8

    AST_CAPTURE_A: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && bc_valid && st_q.qa != '0 && st_q.qa == bc_tag)
        |=> (st_q.qa == '0 && st_q.va == $past(bc_data))); // R5

    AST_FREE_ON_OWN: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && bc_valid && bc_tag == OWN_TAG) |=> !st_q.busy); // R6

    AST_ISSUE_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (alloc && !st_q.busy && bc_valid && iss_a_tag != '0 && iss_a_tag == bc_tag)
        |=> (st_q.qa == '0 && st_q.va == $past(bc_data))); // R9

endmodule

// File: rtl/rs_bank.sv
module rs_bank
    import rs_bank_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int BASE_TAG  = 1,
    localparam int IW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b
);
    logic [NUM_SLOTS-1:0] busy_vec, ready_vec, free_vec;
    logic [NUM_SLOTS-1:0] alloc_gnt, disp_gnt;
    logic [IW-1:0]        free_idx, disp_idx;
    op_t                  op_arr [NUM_SLOTS];
    data_t                va_arr [NUM_SLOTS];
    data_t                vb_arr [NUM_SLOTS];

    assign free_vec = ~busy_vec;

    rs_pick #(.N(NUM_SLOTS)) i_free_pick (
        .req (free_vec),
        .gnt (alloc_gnt),
        .idx (free_idx),
        .any (iss_ready)
    );

    rs_pick #(.N(NUM_SLOTS)) i_disp_pick (
        .req (ready_vec),
        .gnt (disp_gnt),
        .idx (disp_idx),
        .any (disp_valid)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        rs_slot #(.MY_TAG(BASE_TAG + g)) i_slot (
            .clk         (clk),
            .rst         (rst),
            .alloc       (iss_valid && alloc_gnt[g]),
            .iss_op      (iss_op),
            .iss_a_val   (iss_a_val),
            .iss_a_tag   (iss_a_tag),
            .iss_b_val   (iss_b_val),
            .iss_b_tag   (iss_b_tag),
            .bc_valid    (bc_valid),
            .bc_tag      (bc_tag),
            .bc_data     (bc_data),
            .dispatch_go (disp_gnt[g]),
            .busy        (busy_vec[g]),
            .ready       (ready_vec[g]),
            .op          (op_arr[g]),
            .va          (va_arr[g]),
            .vb          (vb_arr[g])
        );
    end

    assign iss_tag  = tag_t'(BASE_TAG) + tag_t'(free_idx);
    assign disp_tag = tag_t'(BASE_TAG) + tag_t'(disp_idx);
    assign disp_op  = op_arr[disp_idx];
    assign disp_a   = va_arr[disp_idx];
    assign disp_b   = vb_arr[disp_idx];

    AST_SINGLE_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(disp_gnt)); // R8

    AST_FULL_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (&busy_vec) |-> !iss_ready); // R3

    AST_DISP_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> ((busy_vec & disp_gnt) != '0)); // R4

endmodule

// File: tb/test_rs_bank.sv
module test_rs_bank;
    localparam int DW = 32;
    localparam int TW = 4;
    localparam int OW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          iss_valid = 1'b0;
    logic [OW-1:0] iss_op = '0;
    logic [DW-1:0] iss_a_val = '0, iss_b_val = '0;
    logic [TW-1:0] iss_a_tag = '0, iss_b_tag = '0;
    logic          iss_ready;
    logic [TW-1:0] iss_tag;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_data = '0;
    logic          disp_valid;
    logic [TW-1:0] disp_tag;
    logic [OW-1:0] disp_op;
    logic [DW-1:0] disp_a, disp_b;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    rs_bank i_rs_bank (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
        .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            checks   = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        iss_valid = 1'b0;
        bc_valid  = 1'b0;
    endtask

    task automatic drive_issue(input logic [OW-1:0] op, input logic [DW-1:0] av, input logic [TW-1:0] at,
                               input logic [DW-1:0] bv, input logic [TW-1:0] bt);
        iss_valid = 1'b1; iss_op = op;
        iss_a_val = av; iss_a_tag = at; iss_b_val = bv; iss_b_tag = bt;
    endtask

    task automatic drive_bc(input logic [TW-1:0] t, input logic [DW-1:0] d);
        bc_valid = 1'b1; bc_tag = t; bc_data = d;
    endtask

    task automatic check_disp(input string req, input logic [TW-1:0] t, input logic [OW-1:0] op,
                              input logic [DW-1:0] a, input logic [DW-1:0] b);
        chk(req, 32'(disp_valid), 1);
        chk(req, 32'(disp_tag), 32'(t));
        chk(req, 32'(disp_op), 32'(op));
        chk(req, disp_a, a);
        chk(req, disp_b, b);
    endtask

    // Free a single slot by broadcasting its own tag
    task automatic release_slot(input logic [TW-1:0] t);
        drive_bc(t, 32'hDEAD);
        tick(); quiet();
    endtask

    task automatic t_reset();
        tick();
        chk("R1", 32'(iss_ready), 1);
        chk("R1", 32'(iss_tag), 1);
        chk("R1", 32'(disp_valid), 0);
    endtask

    task automatic t_basic();
        drive_issue(4'd1, 32'd10, 4'd0, 32'd0, 4'd4);
        tick(); quiet();
        chk("R4", 32'(disp_valid), 0);
        chk("R2", 32'(iss_tag), 2);
        drive_bc(4'd4, 32'd20);
        tick(); quiet();
        check_disp("R5", 4'd1, 4'd1, 32'd10, 32'd20);
        tick();
        chk("R8", 32'(disp_valid), 0);
        drive_bc(4'd1, 32'd0);
        tick(); quiet();
        chk("R6", 32'(iss_tag), 1);
        chk("R6", 32'(iss_ready), 1);
        chk("R6", 32'(disp_valid), 0);
    endtask

    task automatic t_full_and_multi();
        drive_issue(4'd2, 32'd0, 4'd5, 32'd1, 4'd0); tick();
        chk("R2", 32'(iss_tag), 2);
        drive_issue(4'd3, 32'd0, 4'd5, 32'd2, 4'd0); tick();
        drive_issue(4'd4, 32'd0, 4'd5, 32'd3, 4'd0); tick(); quiet();
        chk("R3", 32'(iss_ready), 0);
        drive_issue(4'd7, 32'd99, 4'd0, 32'd99, 4'd0);
        tick(); quiet();
        chk("R3", 32'(disp_valid), 0);
        chk("R3", 32'(iss_ready), 0);
        drive_bc(4'd5, 32'd55);
        tick(); quiet();
        check_disp("R7", 4'd1, 4'd2, 32'd55, 32'd1);
        tick();
        check_disp("R7", 4'd2, 4'd3, 32'd55, 32'd2);
        tick();
        check_disp("R8", 4'd3, 4'd4, 32'd55, 32'd3);
        tick();
        chk("R8", 32'(disp_valid), 0);
        release_slot(4'd1);
        release_slot(4'd2);
        release_slot(4'd3);
        chk("R6", 32'(iss_ready), 1);
        chk("R6", 32'(iss_tag), 1);
        chk("R3", 32'(disp_valid), 0);
    endtask

    task automatic t_bypass();
        drive_issue(4'd5, 32'd0, 4'd6, 32'd0, 4'd7);
        drive_bc(4'd6, 32'd66);
        tick(); quiet();
        drive_bc(4'd7, 32'd77);
        tick(); quiet();
        check_disp("R9", 4'd1, 4'd5, 32'd66, 32'd77);
        tick();
        release_slot(4'd1);
    endtask

    task automatic t_nomatch();
        drive_issue(4'd6, 32'd0, 4'd8, 32'd3, 4'd0);
        tick(); quiet();
        drive_bc(4'd9, 32'd1);
        tick(); quiet();
        chk("R10", 32'(disp_valid), 0);
        chk("R10", 32'(iss_tag), 2);
        drive_bc(4'd8, 32'd80);
        tick(); quiet();
        check_disp("R5", 4'd1, 4'd6, 32'd80, 32'd3);
        tick();
        release_slot(4'd1);
    endtask

    task automatic t_order();
        drive_issue(4'd1, 32'd0, 4'd4, 32'd0, 4'd0); tick();
        drive_issue(4'd2, 32'd11, 4'd0, 32'd12, 4'd0); tick(); quiet();
        check_disp("R8", 4'd2, 4'd2, 32'd11, 32'd12);
        tick();
        chk("R8", 32'(disp_valid), 0);
        drive_bc(4'd4, 32'd4);
        tick(); quiet();
        check_disp("R8", 4'd1, 4'd1, 32'd4, 32'd0);
        tick();
        release_slot(4'd1);
        release_slot(4'd2);
        chk("R6", 32'(iss_tag), 1);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_basic();
        t_full_and_multi();
        t_bypass();
        t_nomatch();
        t_order();
        tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule